// File: doc/BRIEF.md
# Way-Partitioned Pseudo-LRU Victim Selector

This block picks the way to replace in a set-associative cache whose ways are split between different uses. Configuration assigns each way on its own to one of four uses: shared cache, cache for instruction fetches only, cache for data only, or mapped SRAM. For each set the block keeps a binary-tree pseudo-LRU state of one bit per internal node. Every hit and every completed fill moves that state so that the tree points away from the way that was touched.

When a lookup misses, the block walks the tree for the addressed set. At each node it follows the stored bit. If the subtree that the bit points to holds no way the request may use, it takes the other subtree. Instruction fetches may use shared and instruction-only ways. Data accesses and stash writes may use shared and data-only ways. A way that is configured as SRAM is never chosen.

A stash write allocates only when the request carries an explicit stash flag or when its address lies inside a programmed window. The result is registered: the chosen way, the allocate decision and a flag for "no usable way" appear one cycle after the miss. Tags, data arrays, error protection and coherency are outside this block.

Top module: `plru_victim_select`

## Requirements
- R1: One cycle after a miss (`req_valid`=1 with `req_hit`=0), `vict_valid` is 1 for exactly one cycle. In every other cycle it is 0, including the cycle after a hit or after a fill.
- R2: The set index is `req_addr[6 +: SET_W]` for 64-byte lines. Address bits above the index do not select a set. Each set keeps its own tree state.
- R3: Way modes are 2-bit fields, with way w at `cfg_way_mode[2w+1:2w]`: 0 = shared, 1 = instruction-only, 2 = data-only, 3 = SRAM. Request classes are 0 = instruction, 1 = data, 2 = stash, 3 = reserved. An instruction request may use modes 0 and 1. Data and stash requests may use modes 0 and 2. A reserved-class request may use no way. A data or instruction miss with a usable way reports `vict_alloc`=1.
- R4: A way in mode 3 is never reported as the victim, even when the stored tree bits point at it.
- R5: Each set has NUM_WAYS-1 tree bits. At a node, bit value 0 points at the lower-numbered half and 1 points at the upper half. After reset, with every way usable, the victim is way 0.
- R6: A hit or a fill sets each node on the path to the touched way so that the node points at the other half.
- R7: When the subtree that a node's bit indicates contains no usable way for the request class, the walk takes the sibling subtree.
- R8: When no way is usable for the class, the block reports `vict_none`=1, `vict_alloc`=0 and `vict_way`=0. A miss never changes tree state.
- R9: A stash miss allocates only if `req_stash_explicit` is 1, or if `cfg_stash_win_en` is 1 and `cfg_stash_base` <= `req_addr` <= `cfg_stash_limit`. Otherwise it reports `vict_alloc`=0 and still reports the chosen way.
- R10: When a hit and a fill reach the tree in the same cycle, both are applied. On nodes that both paths share, the fill's value wins.
- R11: Reset clears every tree bit and drives all four victim outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_way_mode | input | 2*NUM_WAYS | Per-way mode fields |
| cfg_stash_base | input | ADDR_W | Lowest address in the stash window |
| cfg_stash_limit | input | ADDR_W | Highest address in the stash window |
| cfg_stash_win_en | input | 1 | Enables the stash address window |
| req_valid | input | 1 | A lookup result is presented |
| req_class | input | 2 | Request class code |
| req_addr | input | ADDR_W | Request byte address |
| req_stash_explicit | input | 1 | Stash request flagged for allocation |
| req_hit | input | 1 | The lookup hit |
| req_hit_way | input | $clog2(NUM_WAYS) | Way that hit |
| fill_done | input | 1 | A line fill completed |
| fill_set | input | $clog2(NUM_SETS) | Set of the completed fill |
| fill_way | input | $clog2(NUM_WAYS) | Way of the completed fill |
| vict_valid | output | 1 | Victim result valid |
| vict_way | output | $clog2(NUM_WAYS) | Chosen way |
| vict_alloc | output | 1 | The miss should allocate |
| vict_none | output | 1 | No way usable for this class |

## Verification
The bench builds tree states in which the stored bits lead straight into an SRAM way or into a way owned by the other class. A selector that trusts the raw tree would then return a forbidden way, and one that redirects at the wrong level would return a usable way that is not the expected one. It probes the stash window one line below its base, on its last line and one byte past its limit, so an off-by-one compare flips the allocate bit. It drives a same-cycle hit and fill into one set, where applying them in the wrong order changes the next victim. It also checks that a miss with no usable way leaves the tree untouched and that reset returns later victims to way 0.

// File: rtl/plru_vs_pkg.sv
package plru_vs_pkg;

   typedef enum logic [1:0] {
      MODE_SHARED = 2'd0,
      MODE_INSTR  = 2'd1,
      MODE_DATA   = 2'd2,
      MODE_SRAM   = 2'd3
   } way_mode_e;

   typedef enum logic [1:0] {
      CLS_INSTR = 2'd0,
      CLS_DATA  = 2'd1,
      CLS_STASH = 2'd2,
      CLS_RSVD  = 2'd3
   } req_class_e;

endpackage

// File: rtl/plru_vs_eligibility.sv
module plru_vs_eligibility
   import plru_vs_pkg::*;
#(
   parameter int NUM_WAYS     = 32,
   parameter int ADDR_W       = 32,
   parameter bit STASH_WINDOW = 1'b1
) (
   input  logic [2*NUM_WAYS-1:0] way_mode_i,
   input  logic [1:0]            class_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic                  stash_explicit_i,
   input  logic [ADDR_W-1:0]     win_base_i,
   input  logic [ADDR_W-1:0]     win_limit_i,
   input  logic                  win_en_i,
   output logic [NUM_WAYS-1:0]   elig_o,
   output logic                  stash_take_o
);

   logic is_instr;
   logic is_dside;
   logic in_window;

   assign is_instr = (class_i == CLS_INSTR);
   assign is_dside = (class_i == CLS_DATA) || (class_i == CLS_STASH);

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic [1:0] mode;
      assign mode = way_mode_i[2*w +: 2];
      assign elig_o[w] = (is_instr && (mode == MODE_SHARED || mode == MODE_INSTR)) ||
                         (is_dside && (mode == MODE_SHARED || mode == MODE_DATA));
   end

   if (STASH_WINDOW) begin : g_window
      assign in_window = win_en_i && (addr_i >= win_base_i) && (addr_i <= win_limit_i);
   end else begin : g_no_window
      logic unused_win;
      assign unused_win = ^{win_base_i, win_limit_i, win_en_i, addr_i};
      assign in_window  = 1'b0;
   end

   assign stash_take_o = (class_i == CLS_STASH) && (stash_explicit_i || in_window);

endmodule

// File: rtl/plru_vs_tree_walk.sv
module plru_vs_tree_walk #(
   parameter int NUM_WAYS = 32,
   localparam int WAY_W   = $clog2(NUM_WAYS),
   localparam int NODES   = NUM_WAYS - 1
) (
   input  logic [NODES-1:0]    tree_i,
   input  logic [NUM_WAYS-1:0] elig_i,
   output logic [WAY_W-1:0]    way_o,
   output logic                any_o
);

   // Heap-numbered eligibility: node n covers children 2n and 2n+1,
   // leaves occupy NUM_WAYS .. 2*NUM_WAYS-1.
   logic [2*NUM_WAYS-1:1] sub_ok;

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_leaf
      assign sub_ok[NUM_WAYS + w] = elig_i[w];
   end

   for (genvar n = NUM_WAYS - 1; n >= 1; n--) begin : g_node
      assign sub_ok[n] = sub_ok[2*n] | sub_ok[2*n + 1];
   end

   assign any_o = sub_ok[1];

   logic [WAY_W:0] node;
   logic           stored;
   logic           left_ok;
   logic           right_ok;
   logic           go_right;

   always_comb begin
      node     = (WAY_W+1)'(1);
      stored   = 1'b0;
      left_ok  = 1'b0;
      right_ok = 1'b0;
      go_right = 1'b0;
      for (int l = 0; l < WAY_W; l++) begin
         stored   = tree_i[node[WAY_W-1:0] - WAY_W'(1)];
         left_ok  = sub_ok[{node[WAY_W-1:0], 1'b0}];
         right_ok = sub_ok[{node[WAY_W-1:0], 1'b1}];
         go_right = stored ? right_ok : !left_ok;
         node     = {node[WAY_W-1:0], go_right};
      end
      way_o = node[WAY_W-1:0];
   end

endmodule

// File: rtl/plru_vs_tree_store.sv
module plru_vs_tree_store #(
   parameter int NUM_WAYS = 32,
   parameter int NUM_SETS = 64,
   localparam int WAY_W   = $clog2(NUM_WAYS),
   localparam int SET_W   = $clog2(NUM_SETS),
   localparam int NODES   = NUM_WAYS - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set_i,
   output logic [NODES-1:0] rd_tree_o,
   input  logic             hit_en_i,
   input  logic [SET_W-1:0] hit_set_i,
   input  logic [WAY_W-1:0] hit_way_i,
   input  logic             fill_en_i,
   input  logic [SET_W-1:0] fill_set_i,
   input  logic [WAY_W-1:0] fill_way_i
);

   logic [NUM_SETS-1:0][NODES-1:0] tree_q;
   logic [NUM_SETS-1:0][NODES-1:0] tree_d;

   function automatic logic [NODES-1:0] steer_away(input logic [NODES-1:0] cur,
                                                   input logic [WAY_W-1:0] way);
      logic [NODES-1:0] nxt;
      logic [WAY_W:0]   node;
      logic             dir;
      nxt  = cur;
      node = (WAY_W+1)'(1);
      for (int l = 0; l < WAY_W; l++) begin
         dir = way[WAY_W-1-l];
         nxt[node[WAY_W-1:0] - WAY_W'(1)] = ~dir;
         node = {node[WAY_W-1:0], dir};
      end
      return nxt;
   endfunction

   // Fill is applied after the hit, so it owns any shared node.
   always_comb begin
      tree_d = tree_q;
      if (hit_en_i)  tree_d[hit_set_i]  = steer_away(tree_d[hit_set_i], hit_way_i);
      if (fill_en_i) tree_d[fill_set_i] = steer_away(tree_d[fill_set_i], fill_way_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tree_q <= '0;
      else        tree_q <= tree_d;
   end

   assign rd_tree_o = tree_q[rd_set_i];

   // R8: without a hit or a fill (a miss alone included) no tree bit moves
   assert_miss_keeps_tree_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_en_i && !fill_en_i) |=> $stable(tree_q));

endmodule

// File: rtl/plru_victim_select.sv
module plru_victim_select
   import plru_vs_pkg::*;
#(
   parameter int NUM_WAYS     = 32,
   parameter int NUM_SETS     = 64,
   parameter int ADDR_W       = 32,
   parameter int LINE_BYTES   = 64,
   parameter bit STASH_WINDOW = 1'b1,
   localparam int WAY_W       = $clog2(NUM_WAYS),
   localparam int SET_W       = $clog2(NUM_SETS),
   localparam int OFFSET_W    = $clog2(LINE_BYTES),
   localparam int NODES       = NUM_WAYS - 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2*NUM_WAYS-1:0] cfg_way_mode,
   input  logic [ADDR_W-1:0]     cfg_stash_base,
   input  logic [ADDR_W-1:0]     cfg_stash_limit,
   input  logic                  cfg_stash_win_en,
   input  logic                  req_valid,
   input  logic [1:0]            req_class,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic                  req_stash_explicit,
   input  logic                  req_hit,
   input  logic [WAY_W-1:0]      req_hit_way,
   input  logic                  fill_done,
   input  logic [SET_W-1:0]      fill_set,
   input  logic [WAY_W-1:0]      fill_way,
   output logic                  vict_valid,
   output logic [WAY_W-1:0]      vict_way,
   output logic                  vict_alloc,
   output logic                  vict_none
);

   if (NUM_WAYS < 2 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two of at least 2");
   end
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("NUM_SETS must be a power of two of at least 2");
   end
   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (ADDR_W < OFFSET_W + SET_W) begin : g_bad_addr
      $error("ADDR_W too narrow for line offset plus set index");
   end

   logic [SET_W-1:0]    req_set;
   logic                miss;
   logic                hit_en;
   logic [NODES-1:0]    set_tree;
   logic [NUM_WAYS-1:0] elig_mask;
   logic                stash_take;
   logic [WAY_W-1:0]    walk_way;
   logic                any_elig;
   logic                alloc_now;

   assign req_set = req_addr[OFFSET_W +: SET_W];
   assign miss    = req_valid && !req_hit;
   assign hit_en  = req_valid && req_hit;

   plru_vs_eligibility #(
      .NUM_WAYS     (NUM_WAYS),
      .ADDR_W       (ADDR_W),
      .STASH_WINDOW (STASH_WINDOW)
   ) u_elig (
      .way_mode_i       (cfg_way_mode),
      .class_i          (req_class),
      .addr_i           (req_addr),
      .stash_explicit_i (req_stash_explicit),
      .win_base_i       (cfg_stash_base),
      .win_limit_i      (cfg_stash_limit),
      .win_en_i         (cfg_stash_win_en),
      .elig_o           (elig_mask),
      .stash_take_o     (stash_take)
   );

   plru_vs_tree_store #(
      .NUM_WAYS (NUM_WAYS),
      .NUM_SETS (NUM_SETS)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_set_i   (req_set),
      .rd_tree_o  (set_tree),
      .hit_en_i   (hit_en),
      .hit_set_i  (req_set),
      .hit_way_i  (req_hit_way),
      .fill_en_i  (fill_done),
      .fill_set_i (fill_set),
      .fill_way_i (fill_way)
   );

   plru_vs_tree_walk #(
      .NUM_WAYS (NUM_WAYS)
   ) u_walk (
      .tree_i (set_tree),
      .elig_i (elig_mask),
      .way_o  (walk_way),
      .any_o  (any_elig)
   );

   assign alloc_now = any_elig && ((req_class != CLS_STASH) || stash_take);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vict_valid <= 1'b0;
         vict_way   <= '0;
         vict_alloc <= 1'b0;
         vict_none  <= 1'b0;
      end else begin
         vict_valid <= miss;
         if (miss) begin
            vict_way   <= any_elig ? walk_way : '0;
            vict_alloc <= alloc_now;
            vict_none  <= !any_elig;
         end
      end
   end

   // R7: the walk lands on a way the class may use whenever one exists
   assert_victim_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (miss && any_elig) |-> elig_mask[walk_way]);

   // R4: an SRAM way is never the walk result
   assert_never_sram_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (miss && any_elig) |-> (cfg_way_mode[{walk_way, 1'b0} +: 2] != MODE_SRAM));

   // R1: a miss produces a result in the next cycle
   assert_valid_after_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
      miss |=> vict_valid);

   // R1: no result without a miss
   assert_no_stray_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !miss |=> !vict_valid);

   // R8: an empty candidate set never allocates
   assert_none_blocks_alloc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vict_valid && vict_none) |-> (!vict_alloc && vict_way == '0));

endmodule

// File: tb/tb_plru_victim_select.sv
`timescale 1ns/1ps
module tb_plru_victim_select;

   localparam int NW = 8;
   localparam int NS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_way_mode;
   logic [31:0] cfg_stash_base, cfg_stash_limit;
   logic        cfg_stash_win_en;
   logic        req_valid, req_stash_explicit, req_hit, fill_done;
   logic [1:0]  req_class;
   logic [31:0] req_addr;
   logic [2:0]  req_hit_way, fill_way;
   logic [1:0]  fill_set;
   logic        vict_valid, vict_alloc, vict_none;
   logic [2:0]  vict_way;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   plru_victim_select #(.NUM_WAYS(NW), .NUM_SETS(NS)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_way_mode(cfg_way_mode),
      .cfg_stash_base(cfg_stash_base), .cfg_stash_limit(cfg_stash_limit),
      .cfg_stash_win_en(cfg_stash_win_en), .req_valid(req_valid),
      .req_class(req_class), .req_addr(req_addr),
      .req_stash_explicit(req_stash_explicit), .req_hit(req_hit),
      .req_hit_way(req_hit_way), .fill_done(fill_done), .fill_set(fill_set),
      .fill_way(fill_way), .vict_valid(vict_valid), .vict_way(vict_way),
      .vict_alloc(vict_alloc), .vict_none(vict_none)
   );

   // ways: 0 shared, 1-2 instr, 3-4 data, 5 SRAM, 6 data, 7 shared
   localparam logic [15:0] MODES = 16'h2E94;

   typedef struct packed {
      logic [1:0]  op;    // 0 miss, 1 hit, 2 fill
      logic [1:0]  cls;
      logic [31:0] addr;
      logic        expl;
      logic [2:0]  way;
      logic [2:0]  ew;
      logic        ea;
      logic        en;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 2'd0, 32'h0000, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 8'd5},  // R5 fresh tree -> way 0
      '{2'd2, 2'd0, 32'h0000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 8'd6},  // R6 fill way 0
      '{2'd0, 2'd1, 32'h0000, 1'b0, 3'd0, 3'd4, 1'b1, 1'b0, 8'd6},  // R6 tree points right
      '{2'd0, 2'd0, 32'h0000, 1'b0, 3'd0, 3'd7, 1'b1, 1'b0, 8'd7},  // R7 two redirections
      '{2'd2, 2'd0, 32'h0000, 1'b0, 3'd7, 3'd0, 1'b0, 1'b0, 8'd6},  // R6 fill way 7
      '{2'd0, 2'd0, 32'h0000, 1'b0, 3'd0, 3'd2, 1'b1, 1'b0, 8'd6},  // R6
      '{2'd0, 2'd1, 32'h0000, 1'b0, 3'd0, 3'd3, 1'b1, 1'b0, 8'd7},  // R7 leaf redirect
      '{2'd1, 2'd1, 32'h0000, 1'b0, 3'd3, 3'd0, 1'b0, 1'b0, 8'd1},  // R1 hit way 3, no result
      '{2'd0, 2'd1, 32'h0000, 1'b0, 3'd0, 3'd4, 1'b1, 1'b0, 8'd6},  // R6 after hit
      '{2'd0, 2'd2, 32'h0000, 1'b0, 3'd0, 3'd4, 1'b0, 1'b0, 8'd9},  // R9 stash, no flag, outside
      '{2'd0, 2'd2, 32'h0000, 1'b1, 3'd0, 3'd4, 1'b1, 1'b0, 8'd9},  // R9 explicit
      '{2'd0, 2'd2, 32'h4000, 1'b0, 3'd0, 3'd4, 1'b1, 1'b0, 8'd9},  // R9 window base
      '{2'd0, 2'd2, 32'h7FC0, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 8'd9},  // R9 last line, set 3
      '{2'd0, 2'd2, 32'h8000, 1'b0, 3'd0, 3'd4, 1'b0, 1'b0, 8'd9},  // R9 past limit
      '{2'd0, 2'd2, 32'h3FC0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 8'd9},  // R9 below base, set 3
      '{2'd0, 2'd3, 32'h0040, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 8'd3},  // R3 reserved class
      '{2'd0, 2'd1, 32'h0040, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 8'd2},  // R2 set 1 untouched
      '{2'd0, 2'd1, 32'h0100, 1'b0, 3'd0, 3'd4, 1'b1, 1'b0, 8'd2},  // R2 aliases to set 0
      '{2'd1, 2'd1, 32'h0000, 1'b0, 3'd4, 3'd0, 1'b0, 1'b0, 8'd6},  // R6 hit way 4
      '{2'd1, 2'd1, 32'h0000, 1'b0, 3'd7, 3'd0, 1'b0, 1'b0, 8'd6},  // R6 hit way 7
      '{2'd1, 2'd1, 32'h0000, 1'b0, 3'd3, 3'd0, 1'b0, 1'b0, 8'd6},  // R6 hit way 3
      '{2'd0, 2'd1, 32'h0000, 1'b0, 3'd0, 3'd4, 1'b1, 1'b0, 8'd4},  // R4 bits lead to SRAM way 5
      '{2'd0, 2'd0, 32'h0000, 1'b0, 3'd0, 3'd7, 1'b1, 1'b0, 8'd3}   // R3 instr avoids data ways
   };

   task automatic chk(input string what, input int req, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic idle();
      req_valid = 1'b0; req_hit = 1'b0; fill_done = 1'b0; req_stash_explicit = 1'b0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic miss(input logic [1:0] cls, input logic [31:0] addr, input logic expl);
      req_valid = 1'b1; req_hit = 1'b0; req_class = cls; req_addr = addr;
      req_stash_explicit = expl;
      step();
   endtask

   task automatic expect_result(input int req, input logic [2:0] w, input logic a,
                                input logic n);
      chk("valid", req, 32'(vict_valid), 32'd1);
      chk("way",   req, 32'(vict_way),   32'(w));
      chk("alloc", req, 32'(vict_alloc), 32'(a));
      chk("none",  req, 32'(vict_none),  32'(n));
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      cfg_way_mode = MODES; cfg_stash_base = 32'h4000; cfg_stash_limit = 32'h7FFF;
      cfg_stash_win_en = 1'b1; req_class = 2'd0; req_addr = '0; req_hit_way = '0;
      fill_set = '0; fill_way = '0;
      idle();
      repeat (3) @(negedge clk);
      // R11: outputs held at zero under reset
      chk("reset valid", 11, 32'(vict_valid), 0);
      chk("reset way",   11, 32'(vict_way),   0);
      chk("reset alloc", 11, 32'(vict_alloc), 0);
      chk("reset none",  11, 32'(vict_none),  0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VECS[i];
         case (v.op)
            2'd0: begin
               req_valid = 1'b1; req_hit = 1'b0; req_class = v.cls; req_addr = v.addr;
               req_stash_explicit = v.expl;
            end
            2'd1: begin
               req_valid = 1'b1; req_hit = 1'b1; req_class = v.cls; req_addr = v.addr;
               req_hit_way = v.way;
            end
            default: begin
               fill_done = 1'b1; fill_set = v.addr[7:6]; fill_way = v.way;
            end
         endcase
         step();
         if (v.op == 2'd0) expect_result(int'(v.req), v.ew, v.ea, v.en);
         else chk("no result after hit/fill (R1)", int'(v.req), 32'(vict_valid), 0);
      end

      // R8: every way SRAM -> nothing usable, then tree unchanged
      cfg_way_mode = 16'hFFFF;
      miss(2'd1, 32'h0000, 1'b0);
      expect_result(8, 3'd0, 1'b0, 1'b1);
      step();
      chk("valid drops after one cycle (R1)", 1, 32'(vict_valid), 0);
      cfg_way_mode = MODES;
      miss(2'd1, 32'h0000, 1'b0);
      expect_result(8, 3'd4, 1'b1, 1'b0);

      // R10: same-cycle hit way 0 and fill way 7 on set 2
      req_valid = 1'b1; req_hit = 1'b1; req_class = 2'd1; req_addr = 32'h0080;
      req_hit_way = 3'd0; fill_done = 1'b1; fill_set = 2'd2; fill_way = 3'd7;
      step();
      miss(2'd0, 32'h0080, 1'b0);
      expect_result(10, 3'd2, 1'b1, 1'b0);

      // R9: window disabled -> in-window stash does not allocate
      cfg_stash_win_en = 1'b0;
      miss(2'd2, 32'h4000, 1'b0);
      expect_result(9, 3'd4, 1'b0, 1'b0);
      cfg_stash_win_en = 1'b1;

      // R11: reset mid-run clears outputs and tree
      rst_n = 1'b0;
      @(negedge clk);
      chk("reset valid", 11, 32'(vict_valid), 0);
      chk("reset way",   11, 32'(vict_way),   0);
      chk("reset alloc", 11, 32'(vict_alloc), 0);
      rst_n = 1'b1;
      @(negedge clk);
      miss(2'd1, 32'h0000, 1'b0);
      expect_result(11, 3'd0, 1'b1, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule